// File: doc/BRIEF.md
# Dual-Rail Front End for a Binary Synchronous RAM

This block lets logic that carries every bit on two rails, with an alternating phase, use an ordinary single-bit-per-value synchronous RAM. A request is one vector of dual-rail signals: a command bit, an address and write data. A phase detector watches the whole vector. When every signal in the vector carries the same phase, and that phase differs from the phase of the last operation performed, the block converts the vector to plain binary and performs one RAM access.

Only the logical value of each bit is stored, one RAM bit per value. On a read, the stored word is turned back into dual-rail form in the phase of the request that asked for it. The phase of the last performed operation is output as an acknowledge. The requester can see completion from that output, and from the phase of the read data.

Encoding used throughout: for a dual-rail signal (a, b), the phase is a XOR b and the logical value is a. A value v sent in phase p is therefore a = v, b = v XOR p.

Top module: `dr_ram_wrapper`

## Requirements
- R1: After reset, `ack_phase` is 0 and both read-data rail vectors are all zero, which is value 0 in phase 0.
- R2: A request vector whose signals do not all carry the same phase (a XOR b differs between bits) performs no access: `ack_phase`, the read data and the memory contents stay unchanged.
- R3: A consistent request vector whose phase equals `ack_phase` is a repeat and is ignored: no write, no read, no change at the outputs.
- R4: A consistent request in a new phase with command value 1 (rail a of the command = 1) writes the binary word taken from the rail-a bits of the write data into the word selected by the rail-a bits of the address.
- R5: A consistent request in a new phase with command value 0 reads the addressed word, and it appears on `rdat_a` on the cycle after the clock edge that accepted the request.
- R6: Read data is presented in the phase of the request that produced it: `rdat_b` equals `rdat_a` XOR that phase for every bit.
- R7: An accepted write leaves `rdat_a` and `rdat_b` unchanged.
- R8: For every accepted request, read or write, `ack_phase` takes the phase of that request on the clock edge that accepts it.
- R9: The read-data rails always form a consistent word: a XOR b is the same across all bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_a | input | 1 | Command rail a (value 1 = write, 0 = read) |
| cmd_b | input | 1 | Command rail b |
| addr_a | input | 4 | Address rail a |
| addr_b | input | 4 | Address rail b |
| wdat_a | input | 8 | Write data rail a |
| wdat_b | input | 8 | Write data rail b |
| rdat_a | output | 8 | Read data rail a (logical value) |
| rdat_b | output | 8 | Read data rail b (value XOR phase) |
| ack_phase | output | 1 | Phase of the last performed operation |

## Verification
The checker follows the request rails every cycle. It confirms that mixed-phase and repeated vectors leave the acknowledge and the read rails alone, and that each accepted request moves the acknowledge to the request phase. It also checks that a read comes back in the request phase, that a write holds the read rails, and that the read word is always phase-consistent. Only the bench scenarios can show that the stored values are correct: the words read back after random writes, after a mixed-phase write attempt and after a repeated write in the old phase. Those checks need a model of the memory contents.

// File: rtl/dr_ram_pkg.sv
package dr_ram_pkg;
  typedef enum logic {
    CMD_READ  = 1'b0,
    CMD_WRITE = 1'b1
  } dr_cmd_e;

  localparam int unsigned DEF_ADDR_W = 4;
  localparam int unsigned DEF_DATA_W = 8;
endpackage

// File: rtl/dr_phase_detect.sv
module dr_phase_detect #(
  parameter int unsigned N = 13
) (
  input  logic [N-1:0] rail_a,
  input  logic [N-1:0] rail_b,
  output logic         consistent,
  output logic         phase
);
  logic [N-1:0] bit_phase;

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign bit_phase[i] = rail_a[i] ^ rail_b[i];
  end

  assign consistent = (&bit_phase) | ~(|bit_phase);
  assign phase      = bit_phase[0];
endmodule

// File: rtl/dr_to_bin.sv
module dr_to_bin #(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0] rail_a,
  input  logic [N-1:0] rail_b,
  output logic [N-1:0] value
);
  logic [N-1:0] unused_b;
  assign unused_b = rail_b;
  assign value    = rail_a;
endmodule

// File: rtl/bin_to_dr.sv
module bin_to_dr #(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0] value,
  input  logic         phase,
  output logic [N-1:0] rail_a,
  output logic [N-1:0] rail_b
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign rail_a[i] = value[i];
    assign rail_b[i] = value[i] ^ phase;
  end
endmodule

// File: rtl/dr_mem_core.sv
module dr_mem_core #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[addr] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      rdata_q <= mem[addr];
    end
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/dr_ram_wrapper.sv
module dr_ram_wrapper #(
  parameter int unsigned ADDR_W = dr_ram_pkg::DEF_ADDR_W,
  parameter int unsigned DATA_W = dr_ram_pkg::DEF_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_a,
  input  logic              cmd_b,
  input  logic [ADDR_W-1:0] addr_a,
  input  logic [ADDR_W-1:0] addr_b,
  input  logic [DATA_W-1:0] wdat_a,
  input  logic [DATA_W-1:0] wdat_b,
  output logic [DATA_W-1:0] rdat_a,
  output logic [DATA_W-1:0] rdat_b,
  output logic              ack_phase
);
  import dr_ram_pkg::*;

  localparam int unsigned REQ_W = 1 + ADDR_W + DATA_W;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_sync_q[1];

  // consistency of the whole request vector
  logic req_consistent;
  logic req_phase;

  dr_phase_detect #(.N(REQ_W)) u_detect (
    .rail_a     ({cmd_a, addr_a, wdat_a}),
    .rail_b     ({cmd_b, addr_b, wdat_b}),
    .consistent (req_consistent),
    .phase      (req_phase)
  );

  // dual-rail to binary conversion
  logic [REQ_W-1:0] req_bin;

  dr_to_bin #(.N(REQ_W)) u_to_bin (
    .rail_a ({cmd_a, addr_a, wdat_a}),
    .rail_b ({cmd_b, addr_b, wdat_b}),
    .value  (req_bin)
  );

  dr_cmd_e           cmd_bin;
  logic [ADDR_W-1:0] addr_bin;
  logic [DATA_W-1:0] wdat_bin;

  assign cmd_bin  = dr_cmd_e'(req_bin[REQ_W-1]);
  assign addr_bin = req_bin[DATA_W +: ADDR_W];
  assign wdat_bin = req_bin[DATA_W-1:0];

  // acceptance and phase state
  logic ack_q, ack_d;
  logic resp_ph_q, resp_ph_d;
  logic accept, do_wr, do_rd;

  always_comb begin
    accept    = req_consistent & (req_phase != ack_q);
    do_wr     = accept & (cmd_bin == CMD_WRITE);
    do_rd     = accept & (cmd_bin == CMD_READ);
    ack_d     = ack_q;
    resp_ph_d = resp_ph_q;
    if (accept) begin
      ack_d = req_phase;
    end
    if (do_rd) begin
      resp_ph_d = req_phase;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ack_q     <= 1'b0;
      resp_ph_q <= 1'b0;
    end else begin
      ack_q     <= ack_d;
      resp_ph_q <= resp_ph_d;
    end
  end

  // storage, logical value only
  logic [DATA_W-1:0] rd_word;

  dr_mem_core #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .wr_en (do_wr),
    .rd_en (do_rd),
    .addr  (addr_bin),
    .wdata (wdat_bin),
    .rdata (rd_word)
  );

  // binary to dual-rail in the requested phase
  bin_to_dr #(.N(DATA_W)) u_to_dr (
    .value  (rd_word),
    .phase  (resp_ph_q),
    .rail_a (rdat_a),
    .rail_b (rdat_b)
  );

  assign ack_phase = ack_q;
endmodule

// File: rtl/dr_ram_wrapper_chk.sv
module dr_ram_wrapper_chk #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_a,
  input logic              cmd_b,
  input logic [ADDR_W-1:0] addr_a,
  input logic [ADDR_W-1:0] addr_b,
  input logic [DATA_W-1:0] wdat_a,
  input logic [DATA_W-1:0] wdat_b,
  input logic [DATA_W-1:0] rdat_a,
  input logic [DATA_W-1:0] rdat_b,
  input logic              ack_phase
);
  logic [ADDR_W+DATA_W:0] ph_vec;
  logic                   same, ph, acc;
  logic [DATA_W-1:0]      resp_ph;

  assign ph_vec  = {cmd_a, addr_a, wdat_a} ^ {cmd_b, addr_b, wdat_b};
  assign same    = (ph_vec == '0) || (ph_vec == '1);
  assign ph      = ph_vec[0];
  assign acc     = same && (ph != ack_phase);
  assign resp_ph = rdat_a ^ rdat_b;

  a_r2_mixed_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    !same |=> $stable(ack_phase) && $stable(rdat_a) && $stable(rdat_b));

  a_r3_repeat_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (same && ph == ack_phase) |=> $stable(ack_phase) && $stable(rdat_a) && $stable(rdat_b));

  a_r8_ack_follows: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> ack_phase == $past(ph));

  a_r6_read_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !cmd_a) |=> resp_ph == {DATA_W{$past(ph)}});

  a_r7_write_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_a) |=> $stable(rdat_a) && $stable(rdat_b));

  a_r9_resp_consistent: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_ph == '0) || (resp_ph == '1));
endmodule

bind dr_ram_wrapper dr_ram_wrapper_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .cmd_a     (cmd_a),
  .cmd_b     (cmd_b),
  .addr_a    (addr_a),
  .addr_b    (addr_b),
  .wdat_a    (wdat_a),
  .wdat_b    (wdat_b),
  .rdat_a    (rdat_a),
  .rdat_b    (rdat_b),
  .ack_phase (ack_phase)
);

// File: tb/test_dr_ram_wrapper.sv
module test_dr_ram_wrapper;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned AW = 4;
  localparam int unsigned DW = 8;
  localparam int unsigned DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cmd_a, cmd_b;
  logic [AW-1:0] addr_a, addr_b;
  logic [DW-1:0] wdat_a, wdat_b;
  logic [DW-1:0] rdat_a, rdat_b;
  logic          ack_phase;

  int n_chk = 0;
  int n_bad = 0;
  logic          cur_ph;
  logic [DW-1:0] model [DEPTH];

  always #(CLK_PERIOD/2) clk = ~clk;

  dr_ram_wrapper #(.ADDR_W(AW), .DATA_W(DW)) i_dr_ram_wrapper (
    .clk(clk), .rst_n(rst_n),
    .cmd_a(cmd_a), .cmd_b(cmd_b),
    .addr_a(addr_a), .addr_b(addr_b),
    .wdat_a(wdat_a), .wdat_b(wdat_b),
    .rdat_a(rdat_a), .rdat_b(rdat_b),
    .ack_phase(ack_phase)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic c, input logic [AW-1:0] ad, input logic [DW-1:0] d,
                       input logic p);
    cmd_a  = c;   cmd_b  = c ^ p;
    addr_a = ad;  addr_b = ad ^ {AW{p}};
    wdat_a = d;   wdat_b = d ^ {DW{p}};
  endtask

  task automatic do_write(input logic [AW-1:0] ad, input logic [DW-1:0] d);
    logic [DW-1:0] ra, rb;
    @(negedge clk);
    ra = rdat_a; rb = rdat_b;
    cur_ph = ~cur_ph;
    drive(1'b1, ad, d, cur_ph);
    model[ad] = d;
    @(posedge clk); @(negedge clk);
    chk(ack_phase == cur_ph, "R8 write ack", ack_phase, cur_ph);
    chk(rdat_a == ra && rdat_b == rb, "R7 write holds rdat", {rdat_a, rdat_b}, {ra, rb});
  endtask

  task automatic do_read(input logic [AW-1:0] ad, input string req);
    @(negedge clk);
    cur_ph = ~cur_ph;
    drive(1'b0, ad, 8'h00, cur_ph);
    @(posedge clk); @(negedge clk);
    chk(ack_phase == cur_ph, "R8 read ack", ack_phase, cur_ph);
    chk(rdat_a == model[ad], req, rdat_a, model[ad]);
    chk(rdat_b == (model[ad] ^ {DW{cur_ph}}), "R6 read phase", rdat_b, model[ad] ^ {DW{cur_ph}});
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    cur_ph = 1'b0;
    drive(1'b0, '0, '0, 1'b0);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(ack_phase == 1'b0, "R1 ack after reset", ack_phase, 0);
    chk(rdat_a == '0 && rdat_b == '0, "R1 rdat after reset", {rdat_a, rdat_b}, 0);
  endtask

  task automatic t_basic;
    do_write(4'h3, 8'hA5);
    do_write(4'hC, 8'h5A);
    do_read(4'h3, "R5 read A5");
    do_read(4'hC, "R5 read 5A");
    do_write(4'h0, 8'hFF);
    do_write(4'hF, 8'h00);
    do_read(4'h0, "R4 read FF");
    do_read(4'hF, "R4 read 00");
  endtask

  task automatic t_mixed;
    logic [DW-1:0] ra, rb;
    logic          p_old;
    @(negedge clk);
    ra = rdat_a; rb = rdat_b; p_old = cur_ph;
    drive(1'b1, 4'h3, 8'h11, ~cur_ph);
    addr_b[0] = ~addr_b[0];
    repeat (3) @(negedge clk);
    chk(ack_phase == p_old, "R2 mixed ack", ack_phase, p_old);
    chk(rdat_a == ra && rdat_b == rb, "R2 mixed rdat", {rdat_a, rdat_b}, {ra, rb});
    do_read(4'h3, "R2 mixed no write");
  endtask

  task automatic t_repeat;
    logic [DW-1:0] ra, rb;
    @(negedge clk);
    ra = rdat_a; rb = rdat_b;
    drive(1'b1, 4'hC, 8'h77, cur_ph);
    repeat (3) @(negedge clk);
    chk(ack_phase == cur_ph, "R3 repeat ack", ack_phase, cur_ph);
    chk(rdat_a == ra && rdat_b == rb, "R3 repeat rdat", {rdat_a, rdat_b}, {ra, rb});
    do_read(4'hC, "R3 repeat no write");
  endtask

  task automatic t_random;
    for (int i = 0; i < DEPTH; i++) begin
      do_write(AW'(i), DW'($urandom));
    end
    for (int k = 0; k < 2; k++) begin
      for (int i = DEPTH - 1; i >= 0; i--) begin
        do_read(AW'(i), "R5 random readback");
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset;
    t_basic;
    t_mixed;
    t_repeat;
    t_random;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule